// File: doc/BRIEF.md
# Receive Clock-Correction Elastic Buffer

This block sits between the recovered receive clock of a serial link and the local parallel clock of the rest of the chip. Symbols arrive on the recovered clock, each with a flag that marks it as a skip symbol. They leave on the local clock as a stream with a valid flag. The two clocks are nominally equal but differ by up to a few hundred ppm. A plain dual-clock FIFO would therefore slowly fill or drain.

The buffer corrects this drift by watching its own fill level. When the write side finds the buffer above a high watermark, an arriving skip symbol is thrown away instead of stored. When the read side finds the buffer below a low watermark and the symbol at its head is a skip, that skip is presented twice. Data symbols are never dropped or repeated. Each stored skip is repeated at most once. If the buffer still overflows or runs dry, a sticky error flag is raised in the affected clock domain. Pointers cross between the domains in Gray code through multi-stage synchronizers.

Top module: `rx_elastic_buf`

## Requirements
- R1: While its domain reset is low, and after it is released, rd_valid, skip_add and unf_err read 0 (read domain), and skip_drop and ovf_err read 0 (write domain).
- R2: Every symbol written with wr_skip=0 into a buffer that is not full appears exactly once at the read port with rd_skip=0, in write order.
- R3: A skip symbol leaves the read port with rd_skip=1 and the same data value it was written with.
- R4: A skip written while the write-side fill count is above HI_MARK (default 12) is discarded, and skip_drop is high for one write clock in the following cycle.
- R5: When the read-side fill count is below LO_MARK (default 4) and the head symbol is a skip that has not yet been repeated, that skip is output without advancing. skip_add is high with this first copy. The same skip is output again on the next cycle, so one stored skip yields at most two consecutive outputs.
- R6: After reset the read side outputs nothing until its fill count reaches LO_MARK. From then on it delivers one symbol per read clock whenever the buffer is not empty. Under a write clock offset of 200 ppm in either direction, with a skip at least every 16 symbols, no gap ever appears.
- R7: A write that is neither a dropped skip nor accepted because the buffer holds DEPTH entries is discarded without disturbing stored entries. It sets ovf_err, which stays set until write reset.
- R8: Once streaming, a read cycle that finds the buffer empty drives rd_valid low and sets unf_err, which stays set until read reset.
- R9: Each domain's Gray pointer changes by at most one bit per clock of its domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_valid | input | 1 | A symbol is present this write cycle |
| wr_skip | input | 1 | The present symbol is a removable skip |
| wr_data | input | DATA_W | Symbol value |
| rd_clk | input | 1 | Local parallel clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_valid | output | 1 | A symbol is presented this read cycle |
| rd_skip | output | 1 | The presented symbol is a skip |
| rd_data | output | DATA_W | Presented symbol value |
| skip_drop | output | 1 | One-cycle pulse: a skip was discarded (write domain) |
| skip_add | output | 1 | One-cycle pulse: a skip is being repeated (read domain) |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| unf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
The bench builds the block with its defaults: 8-bit symbols, 16 entries, watermarks 12 and 4, and two synchronizer stages. With these values a 200 ppm offset moves the fill by one entry every 5000 cycles, so both watermarks are crossed and corrected several times in a run of about 150,000 cycles. The small depth also lets a directed burst of 20 writes, sent with the read domain held in reset, reach a true overflow. It shows that exactly the first 16 symbols survive and that skips arriving at a full buffer are dropped. Draining the stream with the writer stopped then shows the underflow path and an exact count of every data symbol delivered.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1fs
package rxeb_pkg;
   // read-side operating phase
   typedef enum logic [0:0] {
      RS_FILL = 1'b0,
      RS_RUN  = 1'b1
   } rd_state_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_DEPTH       = 4;
endpackage

// File: rtl/rxeb_sync.sv
`timescale 1ns/1fs
module rxeb_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < rxeb_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("rxeb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rxeb_g2b.sv
`timescale 1ns/1fs
module rxeb_g2b #(
   parameter int W = 5
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign bin[i] = ^gray[W-1:i];
      end
   endgenerate
endmodule

// File: rtl/rxeb_mem.sv
`timescale 1ns/1fs
module rxeb_mem #(
   parameter int W     = 9,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/rxeb_wr_ctl.sv
`timescale 1ns/1fs
module rxeb_wr_ctl #(
   parameter int DEPTH       = 16,
   parameter int AW          = 4,
   parameter int HI_MARK     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_valid,
   input  logic          wr_skip,
   input  logic [AW:0]   rd_gray_x,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [AW:0]   wr_gray,
   output logic          skip_drop,
   output logic          ovf_err
);
   localparam logic [AW:0] HI_V   = (AW+1)'(HI_MARK);
   localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);

   logic [AW:0] wr_bin, wr_bin_nx, rd_gray_s, rd_bin_s, fill;
   logic        full, drop, accept;

   rxeb_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray_x), .q(rd_gray_s)
   );
   rxeb_g2b #(.W(AW+1)) u_rd_g2b (.gray(rd_gray_s), .bin(rd_bin_s));

   always_comb begin
      fill      = wr_bin - rd_bin_s;
      full      = (fill >= FULL_V);
      drop      = wr_valid && wr_skip && (fill > HI_V);
      accept    = wr_valid && !drop && !full;
      wr_bin_nx = wr_bin + {{AW{1'b0}}, accept};
   end

   assign mem_we    = accept;
   assign mem_waddr = wr_bin[AW-1:0];

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_bin    <= '0;
         wr_gray   <= '0;
         skip_drop <= 1'b0;
         ovf_err   <= 1'b0;
      end else begin
         wr_bin    <= wr_bin_nx;
         wr_gray   <= wr_bin_nx ^ (wr_bin_nx >> 1);
         skip_drop <= drop;
         ovf_err   <= ovf_err || (wr_valid && !drop && full);
      end
   end

   // R2: a data symbol into a non-full buffer always advances the pointer
   a_r2_data_kept: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && !wr_skip && !full) |=> (wr_bin == $past(wr_bin) + 1'b1));
   // R4: no drop pulse unless a skip arrived above the watermark
   a_r4_drop_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      !(wr_valid && wr_skip && (fill > HI_V)) |=> !skip_drop);
   // R7: overflow flag is sticky
   a_r7_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      ovf_err |=> ovf_err);
   // R9: Gray pointer steps one bit at most
   a_r9_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/rxeb_rd_ctl.sv
`timescale 1ns/1fs
module rxeb_rd_ctl #(
   parameter int DATA_W      = 8,
   parameter int AW          = 4,
   parameter int LO_MARK     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic [AW:0]       wr_gray_x,
   input  logic              head_skip,
   input  logic [DATA_W-1:0] head_data,
   output logic [AW-1:0]     mem_raddr,
   output logic [AW:0]       rd_gray,
   output logic              rd_valid,
   output logic              rd_skip,
   output logic [DATA_W-1:0] rd_data,
   output logic              skip_add,
   output logic              unf_err
);
   import rxeb_pkg::*;

   localparam logic [AW:0] LO_V = (AW+1)'(LO_MARK);

   rd_state_e   st;
   logic [AW:0] rd_bin, rd_bin_nx, wr_gray_s, wr_bin_s, fill;
   logic        rep_done, empty, low, insert, advance;

   rxeb_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray_x), .q(wr_gray_s)
   );
   rxeb_g2b #(.W(AW+1)) u_wr_g2b (.gray(wr_gray_s), .bin(wr_bin_s));

   always_comb begin
      fill      = wr_bin_s - rd_bin;
      empty     = (fill == '0);
      low       = (fill < LO_V);
      insert    = (st == RS_RUN) && !empty && head_skip && low && !rep_done;
      advance   = (st == RS_RUN) && !empty && !insert;
      rd_bin_nx = rd_bin + {{AW{1'b0}}, advance};
   end

   assign mem_raddr = rd_bin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         st       <= RS_FILL;
         rd_bin   <= '0;
         rd_gray  <= '0;
         rep_done <= 1'b0;
         rd_valid <= 1'b0;
         rd_skip  <= 1'b0;
         rd_data  <= '0;
         skip_add <= 1'b0;
         unf_err  <= 1'b0;
      end else begin
         if (st == RS_FILL && !low) st <= RS_RUN;
         rd_bin   <= rd_bin_nx;
         rd_gray  <= rd_bin_nx ^ (rd_bin_nx >> 1);
         rd_valid <= (st == RS_RUN) && !empty;
         if ((st == RS_RUN) && !empty) begin
            rd_skip <= head_skip;
            rd_data <= head_data;
         end
         if (insert)       rep_done <= 1'b1;
         else if (advance) rep_done <= 1'b0;
         skip_add <= insert;
         unf_err  <= unf_err || ((st == RS_RUN) && empty);
      end
   end

   // R5: a repeat is flagged on a presented skip, and the copy follows
   a_r5_add_on_skip: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      skip_add |-> (rd_valid && rd_skip));
   a_r5_copy_follows: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      skip_add |=> (rd_valid && rd_skip && !skip_add && rd_data == $past(rd_data)));
   // R8: underflow flag is sticky
   a_r8_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      unf_err |=> unf_err);
   // R9: Gray pointer steps one bit at most
   a_r9_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1fs
module rx_elastic_buf #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int HI_MARK     = 12,
   parameter int LO_MARK     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_valid,
   input  logic              wr_skip,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   output logic              rd_valid,
   output logic              rd_skip,
   output logic [DATA_W-1:0] rd_data,
   output logic              skip_drop,
   output logic              skip_add,
   output logic              ovf_err,
   output logic              unf_err
);
   localparam int AW    = $clog2(DEPTH);
   localparam int WORD_W = DATA_W + 1;

   generate
      if ((1 << AW) != DEPTH || DEPTH < rxeb_pkg::MIN_DEPTH) begin : g_bad_depth
         $error("rx_elastic_buf: DEPTH must be a power of two, at least 4");
      end
      if (LO_MARK < 1 || LO_MARK >= HI_MARK || HI_MARK >= DEPTH) begin : g_bad_marks
         $error("rx_elastic_buf: need 1 <= LO_MARK < HI_MARK < DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_elastic_buf: DATA_W must be positive");
      end
   endgenerate

   logic              mem_we;
   logic [AW-1:0]     mem_waddr, mem_raddr;
   logic [WORD_W-1:0] mem_rword;
   logic [AW:0]       wr_gray, rd_gray;

   rxeb_wr_ctl #(
      .DEPTH(DEPTH), .AW(AW), .HI_MARK(HI_MARK), .SYNC_STAGES(SYNC_STAGES)
   ) u_wr (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_skip(wr_skip),
      .rd_gray_x(rd_gray), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .wr_gray(wr_gray), .skip_drop(skip_drop), .ovf_err(ovf_err)
   );

   rxeb_mem #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata({wr_skip, wr_data}),
      .raddr(mem_raddr), .rdata(mem_rword)
   );

   rxeb_rd_ctl #(
      .DATA_W(DATA_W), .AW(AW), .LO_MARK(LO_MARK), .SYNC_STAGES(SYNC_STAGES)
   ) u_rd (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .wr_gray_x(wr_gray),
      .head_skip(mem_rword[WORD_W-1]), .head_data(mem_rword[DATA_W-1:0]),
      .mem_raddr(mem_raddr), .rd_gray(rd_gray), .rd_valid(rd_valid),
      .rd_skip(rd_skip), .rd_data(rd_data), .skip_add(skip_add), .unf_err(unf_err)
   );
endmodule

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/1fs
module rx_elastic_buf_tb;
   localparam int         DW    = 8;
   localparam int         DEPTH = 16;
   localparam logic [7:0] SKIPV = 8'hF7;
   localparam int         SKIP_EVERY = 16;

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   real  wr_half = 2.5;
   always #(2.5) rd_clk = ~rd_clk;
   always #(wr_half) wr_clk = ~wr_clk;

   logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_skip = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid, rd_skip, skip_drop, skip_add, ovf_err, unf_err;
   logic [DW-1:0] rd_data;

   rx_elastic_buf #(.DATA_W(DW), .DEPTH(DEPTH), .HI_MARK(12), .LO_MARK(4), .SYNC_STAGES(2)) u_dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_skip(wr_skip),
      .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
      .rd_skip(rd_skip), .rd_data(rd_data), .skip_drop(skip_drop), .skip_add(skip_add),
      .ovf_err(ovf_err), .unf_err(unf_err)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // write-side generator: 0 idle, 1 stream, 2 directed data, 3 directed skips
   int gen_mode = 0, dir_req = 0, dir_idx = 0, sym_idx = 0, sent = 0, skips_sent = 0;
   always @(negedge wr_clk) begin
      wr_valid <= 1'b0;
      wr_skip  <= 1'b0;
      case (gen_mode)
         1: begin
            wr_valid <= 1'b1;
            if (sym_idx % SKIP_EVERY == SKIP_EVERY - 1) begin
               wr_skip <= 1'b1;
               wr_data <= SKIPV;
               skips_sent++;
            end else begin
               wr_data <= sent[7:0];
               sent++;
            end
            sym_idx++;
         end
         2, 3: if (dir_idx < dir_req) begin
            wr_valid <= 1'b1;
            wr_skip  <= (gen_mode == 3);
            wr_data  <= (gen_mode == 3) ? SKIPV : 8'h40 + dir_idx[7:0];
            dir_idx++;
         end
         default: dir_idx = 0;
      endcase
   end

   int drops = 0, adds = 0;
   always @(negedge wr_clk) if (wr_rst_n && skip_drop) drops++;
   always @(negedge rd_clk) if (rd_rst_n && skip_add) adds++;

   // read-side monitor
   int  chk_mode = 0, exp_cnt = 0, rx_data = 0, rx_skip = 0, skip_run = 0, gap_cnt = 0;
   int  dir_rx = 0, dir_skip = 0;
   bit  gap_watch = 1'b0;
   always @(negedge rd_clk) begin
      if (gap_watch && !rd_valid) gap_cnt++;
      if (rd_valid && chk_mode == 1) begin
         if (rd_skip) begin
            rx_skip++;
            skip_run++;
            chk(rd_data == SKIPV, "R3 skip payload", int'(rd_data), int'(SKIPV));
            chk(skip_run <= 2, "R5 at most one repeat per skip", skip_run, 2);
         end else begin
            chk(rd_data == exp_cnt[7:0], "R2 data order", int'(rd_data), exp_cnt & 255);
            exp_cnt++;
            rx_data++;
            skip_run = 0;
         end
      end else if (rd_valid && chk_mode == 2) begin
         if (rd_skip) dir_skip++;
         else begin
            chk(rd_data == 8'h40 + dir_rx[7:0], "R7 stored entries intact",
                int'(rd_data), 8'h40 + dir_rx);
            dir_rx++;
         end
      end
   end

   initial begin
      int d_fast, a_fast, d0;
      repeat (5) @(negedge rd_clk);
      chk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
      chk(ovf_err == 1'b0 && skip_drop == 1'b0, "R1 write flags in reset", int'(ovf_err), 0);
      chk(unf_err == 1'b0 && skip_add == 1'b0, "R1 read flags in reset", int'(unf_err), 0);

      // phase A: writer 200 ppm fast
      wr_half  = 2.4995;
      chk_mode = 1;
      gen_mode = 1;
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      repeat (3) @(negedge rd_clk);
      chk(rd_valid == 1'b0, "R6 waits for low watermark", int'(rd_valid), 0);
      repeat (200) @(negedge rd_clk);
      chk(rd_valid == 1'b1, "R6 streaming started", int'(rd_valid), 1);
      gap_watch = 1'b1;
      repeat (60000) @(negedge rd_clk);
      d_fast = drops;
      a_fast = adds;
      chk(d_fast > 0, "R4 skips removed under fast writer", d_fast, 1);

      // phase B: writer 200 ppm slow
      wr_half = 2.5005;
      repeat (90000) @(negedge rd_clk);
      chk(adds - a_fast > 0, "R5 skips repeated under slow writer", adds - a_fast, 1);
      gap_watch = 1'b0;
      chk(gap_cnt == 0, "R6 no gaps while streaming", gap_cnt, 0);
      chk(ovf_err == 1'b0, "R7 no overflow with correction", int'(ovf_err), 0);
      chk(unf_err == 1'b0, "R8 no underflow with correction", int'(unf_err), 0);

      // drain
      gen_mode = 0;
      repeat (100) @(negedge rd_clk);
      chk(rx_data == sent, "R2 every data symbol delivered", rx_data, sent);
      chk(rx_skip == skips_sent - drops + adds, "R4 R5 skip accounting",
          rx_skip, skips_sent - drops + adds);
      chk(rd_valid == 1'b0, "R8 no valid when empty", int'(rd_valid), 0);
      chk(unf_err == 1'b1, "R8 underflow flagged", int'(unf_err), 1);

      // reset clears sticky flags
      wr_half  = 2.5;
      chk_mode = 2;
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      repeat (5) @(negedge rd_clk);
      chk(unf_err == 1'b0, "R8 cleared by reset", int'(unf_err), 0);
      chk(ovf_err == 1'b0, "R1 overflow flag after reset", int'(ovf_err), 0);
      chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);

      // overflow with the read side held in reset
      wr_rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
      dir_req  = 20;
      gen_mode = 2;
      repeat (30) @(negedge wr_clk);
      chk(ovf_err == 1'b1, "R7 overflow flagged", int'(ovf_err), 1);
      gen_mode = 0;
      repeat (2) @(negedge wr_clk);
      d0       = drops;
      dir_req  = 3;
      gen_mode = 3;
      repeat (10) @(negedge wr_clk);
      gen_mode = 0;
      repeat (3) @(negedge wr_clk);
      chk(drops - d0 == 3, "R4 skips dropped above watermark", drops - d0, 3);
      chk(ovf_err == 1'b1, "R7 overflow flag sticky", int'(ovf_err), 1);

      rd_rst_n = 1'b1;
      repeat (60) @(negedge rd_clk);
      chk(dir_rx == DEPTH, "R7 only first DEPTH symbols kept", dir_rx, DEPTH);
      chk(dir_skip == 0, "R4 dropped skips never emitted", dir_skip, 0);
      chk(unf_err == 1'b1, "R8 underflow after drain", int'(unf_err), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(950000.0);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule